// File: doc/BRIEF.md
# Roulette Spin and Result Controller

This block runs a 37-position electronic roulette. It samples a play push button at a slow rate. While the button is held, a two-digit BCD counter steps through the numbers 0 to 36 at a fast rate. At the same time, the LED wheel shows a single lit position that moves slowly around the ring. When the sampled button is seen released, the fast count becomes the result. The result's LED is then lit and held until the next play.

When the result is the house number 0, a tone output is gated on for a fixed number of sample periods. Everything runs from one system clock. The fast count rate, the button sampling rate, the wheel rotation rate and the tone rate arrive as single-cycle enable strobes from outside the block.

Top module: `roulette_ctrl`

## Requirements
- R1: After reset, only LED bit 0 is high (result 0) and the beep output is low.
- R2: The result counter is BCD. Each counting step moves it up by one through the values 0–9 and then 10–36. The ones digit rolls from 9 to 0 and carries into the tens digit.
- R3: A step taken at 36 returns the counter to 0. This is done by a synchronous clear that has priority over counting.
- R4: The counter advances only on a play strobe while the controller is in the playing state. At all other times it holds its value, even when play strobes arrive.
- R5: The button is looked at only on a sample strobe. A press seen on a sample strobe starts play. A release seen on a sample strobe ends play. Changes of the button between sample strobes have no effect.
- R6: While playing, the LEDs show one wheel position, not the count. The position advances by one on each spin strobe and wraps from 36 to 0. It resumes from where the previous play left it.
- R7: Ending play captures the count as the result. LED bit n is then lit for result n and held until the next play.
- R8: A result of 0 enables the beep for BEEP_TICKS sample strobes. While enabled, the beep output is a square wave that starts low and toggles on each tone strobe. At all other times it is low, and a nonzero result leaves it low.
- R9: Exactly one bit of the LED output is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| play_tick_i | input | 1 | Fast counting strobe |
| sample_tick_i | input | 1 | Button sampling and beep timer strobe |
| spin_tick_i | input | 1 | Wheel rotation strobe |
| tone_tick_i | input | 1 | Beep square-wave toggle strobe |
| button_i | input | 1 | Play button, high when pressed |
| led_o | output | NUM_POS | One-hot LED wheel, bit n is number n |
| beep_o | output | 1 | Beep square wave |

## Verification
The bench builds the block with 37 positions and BEEP_TICKS set to 3. This lets it watch the whole beep window, including the cycle where it closes, within a few sample strobes. The strobes are driven one cycle at a time by the bench. Play counts of up to 36 per round are therefore enough to reach the 9-to-10 carry, the value 36, the wrap back to 0 and a zero result. Wheel moves of more than 37 steps show the wheel position wrapping independently of the count.

// File: rtl/roulette_pkg.sv
package roulette_pkg;
  typedef enum logic [1:0] {
    ST_SHOW  = 2'd0,
    ST_PLAY  = 2'd1,
    ST_LATCH = 2'd2
  } ctrl_state_e;

  typedef struct packed {
    logic [3:0] tens;
    logic [3:0] ones;
  } bcd2_t;

  function automatic logic [6:0] bcd2_to_bin(bcd2_t v);
    return 7'(v.tens) * 7'd10 + 7'(v.ones);
  endfunction
endpackage

// File: rtl/roulette_fsm.sv
module roulette_fsm
  import roulette_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sample_i,
  input  logic        button_i,
  output ctrl_state_e state_o
);
  ctrl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SHOW:  if (sample_i && button_i)  state_d = ST_PLAY;
      ST_PLAY:  if (sample_i && !button_i) state_d = ST_LATCH;
      ST_LATCH: state_d = ST_SHOW;
      default:  state_d = ST_SHOW;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_SHOW;
    else         state_q <= state_d;

  assign state_o = state_q;

  AST_SAMPLE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_LATCH && !sample_i) |=> $stable(state_q)); // R5
  AST_LATCH_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LATCH) |=> (state_q == ST_SHOW)); // R7
endmodule

// File: rtl/bcd_wrap_counter.sv
module bcd_wrap_counter
  import roulette_pkg::*;
#(
  parameter int unsigned LAST = 36
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  output bcd2_t cnt_o
);
  localparam logic [3:0] LAST_T = 4'(LAST / 10);
  localparam logic [3:0] LAST_O = 4'(LAST % 10);

  bcd2_t cnt_q;
  logic  at_last, sync_clr;

  assign at_last  = (cnt_q.tens == LAST_T) && (cnt_q.ones == LAST_O);
  assign sync_clr = en_i && at_last;  // wrap folded into clear path

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (sync_clr) cnt_q <= '0;
    else if (en_i) begin
      if (cnt_q.ones == 4'd9) begin
        cnt_q.ones <= 4'd0;
        cnt_q.tens <= cnt_q.tens + 4'd1;
      end else begin
        cnt_q.ones <= cnt_q.ones + 4'd1;
      end
    end
  end

  assign cnt_o = cnt_q;

  AST_BCD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q.ones <= 4'd9) && (bcd2_to_bin(cnt_q) <= 7'(LAST))); // R2
  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && bcd2_to_bin(cnt_q) == 7'(LAST)) |=> (cnt_q == '0)); // R3
  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && bcd2_to_bin(cnt_q) != 7'(LAST)) |=>
      (bcd2_to_bin(cnt_q) == bcd2_to_bin($past(cnt_q)) + 7'd1)); // R2
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/spin_wheel.sv
module spin_wheel #(
  parameter int unsigned N = 37,
  localparam int unsigned W = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] pos_o
);
  logic [W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pos_q <= '0;
    else if (en_i) pos_q <= (pos_q == W'(N - 1)) ? '0 : pos_q + W'(1);

  assign pos_o = pos_q;

  AST_WHEEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= W'(N - 1)); // R6
endmodule

// File: rtl/onehot_dec.sv
module onehot_dec #(
  parameter int unsigned N = 37,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [W-1:0] idx_i,
  output logic [N-1:0] oh_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign oh_o[i] = (idx_i == W'(i));
  end
endmodule

// File: rtl/beep_gen.sv
module beep_gen #(
  parameter int unsigned TICKS = 200,
  localparam int unsigned TW = $clog2(TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sample_i,
  input  logic tone_i,
  output logic beep_o
);
  logic [TW-1:0] timer_q;
  logic          tone_q, active;

  assign active = (timer_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_q <= '0;
      tone_q  <= 1'b0;
    end else begin
      if (start_i) timer_q <= TW'(TICKS);
      else if (sample_i && active) timer_q <= timer_q - TW'(1);
      if (!active) tone_q <= 1'b0;
      else if (tone_i) tone_q <= ~tone_q;
    end
  end

  assign beep_o = tone_q && active;

  AST_BEEP_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (timer_q == TW'(TICKS))); // R8
  AST_TIMER_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && sample_i && active) |=> (timer_q == $past(timer_q) - TW'(1))); // R8
  AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !active) |=> !beep_o); // R8
endmodule

// File: rtl/roulette_ctrl.sv
module roulette_ctrl
  import roulette_pkg::*;
#(
  parameter int unsigned NUM_POS    = 37,
  parameter int unsigned BEEP_TICKS = 200
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               play_tick_i,
  input  logic               sample_tick_i,
  input  logic               spin_tick_i,
  input  logic               tone_tick_i,
  input  logic               button_i,
  output logic [NUM_POS-1:0] led_o,
  output logic               beep_o
);
  localparam int unsigned W    = $clog2(NUM_POS);
  localparam int unsigned LAST = NUM_POS - 1;

  ctrl_state_e  state;
  bcd2_t        cnt, result_q;
  logic [W-1:0] wheel_pos, led_idx;
  logic         playing;

  assign playing = (state == ST_PLAY);

  roulette_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample_tick_i),
    .button_i (button_i),
    .state_o  (state)
  );

  bcd_wrap_counter #(.LAST(LAST)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (play_tick_i && playing),
    .cnt_o  (cnt)
  );

  spin_wheel #(.N(NUM_POS)) u_wheel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (spin_tick_i && playing),
    .pos_o  (wheel_pos)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) result_q <= '0;
    else if (state == ST_LATCH) result_q <= cnt;

  assign led_idx = playing ? wheel_pos : W'(bcd2_to_bin(result_q));

  onehot_dec #(.N(NUM_POS)) u_dec (
    .idx_i (led_idx),
    .oh_o  (led_o)
  );

  beep_gen #(.TICKS(BEEP_TICKS)) u_beep (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  ((state == ST_LATCH) && (cnt == '0)),
    .sample_i (sample_tick_i),
    .tone_i   (tone_tick_i),
    .beep_o   (beep_o)
  );

  AST_LED_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(led_o) == 1); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_LATCH) |=> $stable(result_q)); // R7
  AST_NO_PLAY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !playing |=> $stable(cnt)); // R4
endmodule

// File: tb/roulette_ctrl_tb.sv
module roulette_ctrl_tb_top;
  localparam int NP = 37;
  localparam int BT = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic play_t = 0, samp_t = 0, spin_t = 0, tone_t = 0, btn = 0;
  logic [NP-1:0] led;
  logic beep;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  roulette_ctrl #(.NUM_POS(NP), .BEEP_TICKS(BT)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .play_tick_i(play_t), .sample_tick_i(samp_t),
    .spin_tick_i(spin_t), .tone_tick_i(tone_t), .button_i(btn),
    .led_o(led), .beep_o(beep)
  );

  // {play steps, spin steps, expected result, expected wheel}
  localparam int NV = 5;
  localparam int VEC [NV][4] = '{
    '{5, 2, 5, 2}, '{5, 1, 10, 3}, '{26, 3, 36, 6}, '{36, 0, 35, 6}, '{2, 40, 0, 9}
  };

  function automatic logic [NP-1:0] oh(int n);
    return NP'(1) << n;
  endfunction

  task automatic chk_led(string req, logic [NP-1:0] exp);
    n_run++;
    if (led !== exp || $countones(led) != 1) begin
      n_fail++;
      $display("FAIL %s led act=%h exp=%h", req, led, exp);
    end
  endtask

  task automatic chk_beep(string req, logic exp);
    n_run++;
    if (beep !== exp) begin
      n_fail++;
      $display("FAIL %s beep act=%b exp=%b", req, beep, exp);
    end
  endtask

  // one clock with the given strobes, button level persists
  task automatic drive(logic p, logic s, logic sp, logic t, logic b);
    play_t = p; samp_t = s; spin_t = sp; tone_t = t; btn = b;
    @(posedge clk); #1;
    play_t = 0; samp_t = 0; spin_t = 0; tone_t = 0;
  endtask

  task automatic play_round(int np, int ns, int exp_res, int exp_wheel);
    drive(0, 1, 0, 0, 1);
    for (int i = 0; i < np; i++) drive(1, 0, 0, 0, 1);
    for (int i = 0; i < ns; i++) drive(0, 0, 1, 0, 1);
    chk_led("R6 wheel", oh(exp_wheel));
    drive(0, 1, 0, 0, 0);
    drive(0, 0, 0, 0, 0);
    chk_led("R2 R3 R7 result", oh(exp_res));
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk_led("R1 reset", oh(0));
    chk_beep("R1 reset", 1'b0);
    rst_ni = 1'b1;
    drive(0, 0, 0, 0, 0);
    chk_led("R1 after release", oh(0));

    for (int v = 0; v < NV; v++)
      play_round(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

    // R8: result 0 -> beep window of BT sample strobes
    chk_beep("R8 starts low", 1'b0);
    drive(0, 0, 0, 1, 0); chk_beep("R8 toggle1", 1'b1);
    drive(0, 0, 0, 1, 0); chk_beep("R8 toggle2", 1'b0);
    drive(0, 0, 0, 1, 0); chk_beep("R8 toggle3", 1'b1);
    drive(0, 1, 0, 0, 0);
    drive(0, 1, 0, 0, 0); chk_beep("R8 still on", 1'b1);
    drive(0, 1, 0, 0, 0); chk_beep("R8 window end", 1'b0);
    drive(0, 0, 0, 1, 0); chk_beep("R8 after window", 1'b0);
    chk_led("R7 held through beep", oh(0));

    // R8: nonzero result gives no beep
    play_round(1, 1, 1, 10);
    drive(0, 0, 0, 1, 0); chk_beep("R8 nonzero", 1'b0);
    drive(0, 0, 0, 1, 0); chk_beep("R8 nonzero", 1'b0);

    // R5 R4: button without sample strobe is ignored
    drive(0, 0, 0, 0, 1);
    drive(1, 0, 0, 0, 1);
    drive(1, 0, 1, 0, 1);
    drive(1, 0, 0, 0, 1);
    chk_led("R5 no sample, no play", oh(1));
    drive(0, 0, 0, 0, 0);
    play_round(1, 0, 2, 10);

    // R4: play strobes while showing do not move the count
    for (int i = 0; i < 4; i++) drive(1, 0, 0, 0, 0);
    chk_led("R4 show hold", oh(2));
    play_round(0, 0, 2, 10);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule